// File: doc/BRIEF.md
# Gated Period Timer with Real-Time Count

This peripheral holds a 16-bit counter that climbs towards a programmable period value. When it gets there it wraps to zero and raises a sticky interrupt flag. The counter can take its ticks from three sources. The first is every cycle of the core clock. The second is the core clock, but only while an external gate input is high. This lets software measure how long a pulse lasts, and the end of each gate window also raises the flag. The third is the rising edges of a slow external clock, used as a real-time count. A selectable prescaler sits in front of the counter in every mode.

Software reaches five registers over a single-cycle write bus with combinational read data. The registers hold the control fields, the period, the live count, the interrupt flag and the interrupt enable. The core's low-power state comes in on two inputs. Sleep halts all counting derived from the core clock. The asynchronous external-clock mode keeps running through sleep. Idle halts counting only when the stop-in-idle control bit is set.

Top module: `gated_period_timer`

## Requirements
- R1: After reset the registers read as follows: control 0, period 0xFFFF, count 0, flag 0 and enable 0. `irq` is 0.
- R2: Register addresses are 0 control, 1 period, 2 count, 3 flag (bit 0) and 4 enable (bit 0). The control bits are: bit 0 run, bit 1 external clock, bit 2 gated, bit 3 synchronous external, bits 5:4 prescale select and bit 6 stop-in-idle. Unused bits read 0.
- R3: Each prescaled tick raises the count by one. A tick that arrives while the count equals a nonzero period reloads 0 and sets the flag, so the flag appears after period+1 ticks.
- R4: The flag stays set until software writes 0 to it. A hardware event in the same cycle as that write wins.
- R5: `irq` is high exactly when the flag and the enable bit are both 1.
- R6: Prescale select 0, 1, 2 and 3 divide the tick source by 1, 8, 64 and 256.
- R7: A write to the count or control register clears the prescaler's partial count.
- R8: A write to the count register loads the written value, and it overrides any increment in that cycle.
- R9: While the period is 0 the count is held at 0 and no match sets the flag.
- R10: In gated mode with the internal source, the counter counts only while the synchronized gate is high. A falling gate sets the flag. A gate falling edge sets no flag when gated mode is off.
- R11: In external mode each rising edge of `ext_clk` is one tick source event, and the gate level has no effect.
- R12: With `sleep_req` high, counting goes on only in external mode with the synchronous bit at 0. Internal and synchronous external counting stop.
- R13: With `idle_req` high, counting stops when stop-in-idle is 1 and goes on when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| gate_in | input | 1 | External gate, synchronized inside |
| ext_clk | input | 1 | Slow external clock, synchronized inside |
| idle_req | input | 1 | Core is in idle |
| sleep_req | input | 1 | Core is in sleep |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `gate_in` and `ext_clk` change slowly against `clk`, with each level held for at least two cycles, so that no edge is lost in the synchronizers. They also assume that a period value which would strand the count above it is never written while the timer runs. The stimulus holds every external-clock phase for three cycles and every gate window for several cycles. It reprograms period and count only while the timer is stopped, except in the directed load-priority test, where the period is 0xFFFF.

// File: rtl/gated_period_timer.sv
module gated_period_timer #(
  parameter int DW  = 16,
  parameter int AW  = 3,
  parameter int PSW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          gate_in,
  input  logic          ext_clk,
  input  logic          idle_req,
  input  logic          sleep_req,
  output logic          irq
);
  localparam int CW = 7;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_PRD  = AW'(1);
  localparam logic [AW-1:0] A_CNT  = AW'(2);
  localparam logic [AW-1:0] A_FLG  = AW'(3);
  localparam logic [AW-1:0] A_IE   = AW'(4);

  logic [CW-1:0]  ctrl;
  logic [DW-1:0]  prd, cnt;
  logic [PSW-1:0] pre, ps_lim;
  logic           flag, ie;
  logic [2:0]     gs, es;

  wire wr_ctrl = bus_we && (bus_addr == A_CTRL);
  wire wr_prd  = bus_we && (bus_addr == A_PRD);
  wire wr_cnt  = bus_we && (bus_addr == A_CNT);
  wire wr_flg  = bus_we && (bus_addr == A_FLG);
  wire wr_ie   = bus_we && (bus_addr == A_IE);

  wire on    = ctrl[0];
  wire ext   = ctrl[1];
  wire gated = ctrl[2];
  wire syn   = ctrl[3];
  wire [1:0] psel = ctrl[5:4];
  wire sid   = ctrl[6];

  wire g_lvl  = gs[1];
  wire g_fall = gs[2] & ~gs[1];
  wire e_rise = es[1] & ~es[2];

  wire idle_stop = idle_req && sid;
  wire ext_async = ext && !syn;
  wire active    = on && !idle_stop && (ext_async || !sleep_req);
  wire raw       = ext ? e_rise : (gated ? g_lvl : 1'b1);
  wire step      = active && raw;
  wire tick      = step && (pre == ps_lim);
  wire prd_zero  = (prd == '0);
  wire at_prd    = (cnt == prd);
  wire match     = tick && !prd_zero && at_prd && !wr_cnt;
  wire gate_evt  = active && gated && !ext && g_fall;

  always_comb begin
    case (psel)
      2'd0:    ps_lim = PSW'(0);
      2'd1:    ps_lim = PSW'(7);
      2'd2:    ps_lim = PSW'(63);
      default: ps_lim = PSW'(255);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gs <= '0;
      es <= '0;
    end else begin
      gs <= {gs[1:0], gate_in};
      es <= {es[1:0], ext_clk};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      prd  <= '1;
      ie   <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= bus_wdata[CW-1:0];
      if (wr_prd)  prd  <= bus_wdata;
      if (wr_ie)   ie   <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pre <= '0;
    else if (wr_ctrl || wr_cnt) pre <= '0;
    else if (step)             pre <= tick ? '0 : pre + PSW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (wr_cnt)   cnt <= bus_wdata;
    else if (prd_zero) cnt <= '0;
    else if (tick)     cnt <= at_prd ? '0 : cnt + DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= (wr_flg ? bus_wdata[0] : flag) | match | gate_evt;
  end

  assign irq = flag & ie;

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {{(DW-CW){1'b0}}, ctrl};
      A_PRD:   bus_rdata = prd;
      A_CNT:   bus_rdata = cnt;
      A_FLG:   bus_rdata = {{(DW-1){1'b0}}, flag};
      A_IE:    bus_rdata = {{(DW-1){1'b0}}, ie};
      default: bus_rdata = '0;
    endcase
  end

  // R4: flag is sticky unless software writes its register
  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !wr_flg) |=> flag);

  // R3: match wraps to zero and raises the flag
  a_r3_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> (cnt == '0) && flag);

  // R8: a count write lands regardless of ticks
  a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt == $past(bus_wdata)));

  // R9: zero period keeps the count at zero
  a_r9_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_zero && !wr_cnt) |=> (cnt == '0));

  // R12, R13: no count change while halted
  a_r12_halt_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !wr_cnt && !prd_zero) |=> $stable(cnt));

  // R6: prescaler never passes the selected limit
  a_r6_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ctrl && !wr_cnt) |=> (pre <= ps_lim));

  // R5: request falls with the flag
  a_r5_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> !irq);
endmodule

// File: tb/sim_gated_period_timer.sv
`timescale 1ns/1ps
module sim_gated_period_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        gate_in = 1'b0, ext_clk = 1'b0, idle_req = 1'b0, sleep_req = 1'b0;
  logic        irq;
  int          n_chk = 0, n_bad = 0, cyc = 0;
  logic [15:0] v;

  gated_period_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gate_in(gate_in),
    .ext_clk(ext_clk), .idle_req(idle_req), .sleep_req(sleep_req), .irq(irq)
  );

  always #2 clk = ~clk;

  localparam int NV = 10;
  localparam logic [15:0] T_P   [NV] = '{16'd10, 16'd10, 16'd10, 16'd10, 16'd0,
                                          16'd3, 16'd3, 16'd100, 16'd5, 16'hFFFF};
  localparam logic [15:0] T_SEL [NV] = '{16'd0, 16'd0, 16'd0, 16'd0, 16'd0,
                                          16'd1, 16'd1, 16'd2, 16'd3, 16'd0};
  localparam int          T_N   [NV] = '{5, 10, 11, 25, 20, 20, 33, 200, 600, 50};
  localparam logic [15:0] T_CNT [NV] = '{16'd5, 16'd10, 16'd0, 16'd3, 16'd0,
                                          16'd2, 16'd0, 16'd3, 16'd2, 16'd50};
  localparam logic [15:0] T_FLG [NV] = '{16'd0, 16'd0, 16'd1, 16'd1, 16'd0,
                                          16'd0, 16'd1, 16'd0, 16'd0, 16'd0};

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #0.25;
    d = bus_rdata;
  endtask

  task automatic ext_pulses(input int k);
    for (int i = 0; i < k; i++) begin
      ext_clk = 1'b1; repeat (3) @(negedge clk);
      ext_clk = 1'b0; repeat (3) @(negedge clk);
    end
  endtask

  task automatic restart(input logic [15:0] p, input logic [15:0] c);
    wr(3'd0, 16'h0000);
    wr(3'd1, p);
    wr(3'd2, 16'h0000);
    wr(3'd3, 16'h0000);
    wr(3'd0, c);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v); chk("R1 ctrl", v, 16'h0000);
    rd(3'd1, v); chk("R1 period", v, 16'hFFFF);
    rd(3'd2, v); chk("R1 count", v, 16'h0000);
    rd(3'd3, v); chk("R1 flag", v, 16'h0000);
    rd(3'd4, v); chk("R1 enable", v, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'd0);

    // R2 register readback, unused bits zero
    wr(3'd0, 16'hFF68); rd(3'd0, v); chk("R2 ctrl readback", v, 16'h0068);
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h1357); rd(3'd1, v); chk("R2 period readback", v, 16'h1357);

    // R3 R6 R9 vector table, internal source
    for (int i = 0; i < NV; i++) begin
      restart(T_P[i], 16'h0001 | (T_SEL[i] << 4));
      repeat (T_N[i]) @(negedge clk);
      rd(3'd2, v); chk($sformatf("R3/R6/R9 vec%0d count", i), v, T_CNT[i]);
      rd(3'd3, v); chk($sformatf("R3/R9 vec%0d flag", i), v, T_FLG[i]);
    end

    // R4 R5 sticky flag and irq gating
    restart(16'd2, 16'h0001);
    repeat (5) @(negedge clk);
    wr(3'd0, 16'h0000);
    repeat (4) @(negedge clk);
    rd(3'd3, v); chk("R4 flag sticky", v, 16'd1);
    chk("R5 irq masked", {15'd0, irq}, 16'd0);
    wr(3'd4, 16'd1);
    chk("R5 irq enabled", {15'd0, irq}, 16'd1);
    wr(3'd3, 16'd0);
    chk("R5 irq after clear", {15'd0, irq}, 16'd0);
    rd(3'd3, v); chk("R4 flag cleared", v, 16'd0);
    wr(3'd4, 16'd0);

    // R8 load priority while running
    restart(16'hFFFF, 16'h0001);
    repeat (4) @(negedge clk);
    wr(3'd2, 16'h1234);
    rd(3'd2, v); chk("R8 load value", v, 16'h1234);
    @(negedge clk);
    rd(3'd2, v); chk("R8 count after load", v, 16'h1235);

    // R7 prescaler cleared by count write
    restart(16'hFFFF, 16'h0011);
    repeat (5) @(negedge clk);
    wr(3'd2, 16'h0000);
    repeat (7) @(negedge clk);
    rd(3'd2, v); chk("R7 no tick before 8", v, 16'd0);
    @(negedge clk);
    rd(3'd2, v); chk("R7 tick at 8", v, 16'd1);

    // R10 gated accumulation
    restart(16'd1000, 16'h0005);
    repeat (3) @(negedge clk);
    rd(3'd2, v); chk("R10 gate low no count", v, 16'd0);
    gate_in = 1'b1;
    repeat (7) @(negedge clk);
    gate_in = 1'b0;
    repeat (6) @(negedge clk);
    rd(3'd2, v); chk("R10 gate window count", v, 16'd7);
    rd(3'd3, v); chk("R10 gate fall flag", v, 16'd1);
    restart(16'hFFFF, 16'h0001);
    gate_in = 1'b1; repeat (5) @(negedge clk);
    gate_in = 1'b0; repeat (5) @(negedge clk);
    rd(3'd3, v); chk("R10 no flag ungated", v, 16'd0);

    // R11 external clock, gate ignored
    restart(16'd4, 16'h0003);
    gate_in = 1'b1;
    ext_pulses(7);
    gate_in = 1'b0;
    repeat (2) @(negedge clk);
    rd(3'd2, v); chk("R11 ext count wraps", v, 16'd2);
    rd(3'd3, v); chk("R11 ext flag", v, 16'd1);

    // R12 sleep behaviour
    restart(16'd1000, 16'h0003);
    sleep_req = 1'b1;
    ext_pulses(4);
    rd(3'd2, v); chk("R12 async ext in sleep", v, 16'd4);
    restart(16'd1000, 16'h000B);
    ext_pulses(4);
    rd(3'd2, v); chk("R12 sync ext halts", v, 16'd0);
    restart(16'd1000, 16'h0001);
    repeat (10) @(negedge clk);
    rd(3'd2, v); chk("R12 internal halts", v, 16'd0);
    sleep_req = 1'b0;

    // R13 idle behaviour
    idle_req = 1'b1;
    restart(16'd1000, 16'h0041);
    repeat (10) @(negedge clk);
    rd(3'd2, v); chk("R13 stop in idle", v, 16'd0);
    restart(16'd1000, 16'h0001);
    repeat (10) @(negedge clk);
    rd(3'd2, v); chk("R13 run in idle", v, 16'd10);
    idle_req = 1'b0;

    finish_run();
  end
endmodule